// File: doc/BRIEF.md
# Bidirectional Byte-Granular Data FIFO

This block is the data buffer between a 32-bit register interface and a byte-serial flash engine. One store of 32 bytes is used in one direction at a time. In transmit mode the bus side writes 1, 2 or 4 bytes per access and the serial engine drains single bytes. In receive mode the serial engine fills single bytes and the bus side reads 1, 2 or 4 bytes per access. The direction is chosen by a mode input.

An access that cannot be served is held with a stall signal. A write waits for enough free space. A read waits for enough stored bytes, but only while the transfer is still in progress. Once the transfer ends, a pending read completes at once with whatever bytes are present.

The block reports the byte count and a threshold flag whose meaning follows the direction. An abort or disable pulse empties the store in a single cycle.

Top module: `dualdir_byte_fifo`

## Requirements
- R1: After reset the level is 0, the bus stall is low, and in transmit mode (`rx_mode_i`=0) the threshold flag is high.
- R2: In transmit mode, an accepted bus write stores 1, 2 or 4 bytes for `bus_size_i` = 0, 1 or 2/3. Bits 7:0 enter first, then 15:8, and so on. `ser_dout_o` shows the oldest byte, and each `ser_pop_i` removes one byte.
- R3: In receive mode, an accepted bus read removes 1, 2 or 4 bytes (same size encoding). The oldest byte is returned on bits 7:0 and the next bytes on the lanes above it. Unused upper lanes read 0.
- R4: A transmit-mode bus write stalls while the free space is smaller than its size. A stalled write stores nothing.
- R5: A receive-mode bus read stalls while the level is below its size and `busy_i` is high. With `busy_i` low, the read completes in the same cycle and removes only the bytes present. Missing lanes read 0.
- R6: In receive mode, `ser_push_i` adds `ser_din_i` as one byte, and the push is ignored when the level is 32.
- R7: A bus access in the wrong direction (a write in receive mode, or a read in transmit mode) never stalls, returns 0 and leaves the level unchanged. `ser_pop_i` in receive mode and `ser_push_i` in transmit mode have no effect.
- R8: `level_o` equals the number of stored bytes and never exceeds 32.
- R9: `thresh_flag_o` is high when the level is at least `thresh_i`+1 in receive mode. In transmit mode it is high when the free space is at least `thresh_i`+1.
- R10: `clear_i` makes the level 0 on the next cycle, whatever other requests are present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Empty the store (abort or disable) |
| rx_mode_i | input | 1 | 1 = receive direction, 0 = transmit direction |
| busy_i | input | 1 | Transfer in progress; releases read stalls when low |
| thresh_i | input | 5 | Threshold value |
| bus_req_i | input | 1 | Bus data access request |
| bus_we_i | input | 1 | 1 = write access, 0 = read access |
| bus_size_i | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| bus_wdata_i | input | 32 | Write data, low-aligned |
| bus_rdata_o | output | 32 | Read data, low-aligned, valid when accepted |
| bus_stall_o | output | 1 | Access held this cycle |
| ser_push_i | input | 1 | Serial side stores one byte (receive) |
| ser_din_i | input | 8 | Serial byte in |
| ser_pop_i | input | 1 | Serial side takes one byte (transmit) |
| ser_dout_o | output | 8 | Oldest stored byte |
| level_o | output | 6 | Stored byte count |
| thresh_flag_o | output | 1 | Threshold flag |

## Verification
The assertions check these properties on every cycle: the level bound, emptying after a clear, and that a read stall only occurs while busy is high. They also check that a stalled write leaves the level frozen, that a push into a full store is dropped, that wrong-direction accesses never stall, and the receive-side threshold flag. Only the bench's scenarios can show the byte ordering through the store, the partial reads when busy falls, and the exact level after mixed pushes and pops. For these, a reference byte queue is run through phases that fill, drain, overrun and underrun the store in both directions.

// File: rtl/dbf_pkg.sv
package dbf_pkg;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'd0,
        ACC_HALF = 2'd1,
        ACC_WORD = 2'd2,
        ACC_WIDE = 2'd3
    } acc_size_e;

    // bytes moved by one bus access of the given size code
    function automatic logic [2:0] acc_bytes(input logic [1:0] sz);
        case (acc_size_e'(sz))
            ACC_BYTE: acc_bytes = 3'd1;
            ACC_HALF: acc_bytes = 3'd2;
            default:  acc_bytes = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dbf_ctrl.sv
module dbf_ctrl
    import dbf_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int AW    = $clog2(DEPTH),
    parameter int LW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          rx_mode_i,
    input  logic          busy_i,
    input  logic          bus_req_i,
    input  logic          bus_we_i,
    input  logic [1:0]    bus_size_i,
    input  logic          ser_push_i,
    input  logic          ser_pop_i,
    output logic          stall_o,
    output logic [2:0]    put_cnt_o,
    output logic [2:0]    bus_take_o,
    output logic [AW-1:0] wptr_o,
    output logic [AW-1:0] rptr_o,
    output logic [LW-1:0] level_o
);

    localparam logic [LW-1:0] FULL = LW'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [LW-1:0] level;
    } ctrl_t;

    ctrl_t st_d, st_q;

    logic [LW-1:0] nreq, room, bus_put, bus_take, push_n, pop_n;
    logic          dir_ok, short_q, accept, ser_put, ser_take;

    always_comb begin
        nreq     = LW'(acc_bytes(bus_size_i));
        room     = FULL - st_q.level;
        dir_ok   = bus_we_i ? !rx_mode_i : rx_mode_i;
        short_q  = bus_we_i ? (room < nreq) : ((st_q.level < nreq) && busy_i);
        stall_o  = bus_req_i && dir_ok && short_q;
        accept   = bus_req_i && dir_ok && !short_q;
        bus_put  = (accept && bus_we_i) ? nreq : '0;
        bus_take = (accept && !bus_we_i)
                 ? ((st_q.level < nreq) ? st_q.level : nreq) : '0;
        ser_put  = rx_mode_i && ser_push_i && (st_q.level != FULL);
        ser_take = !rx_mode_i && ser_pop_i && (st_q.level != '0);
        push_n   = rx_mode_i ? LW'(ser_put) : bus_put;
        pop_n    = rx_mode_i ? bus_take : LW'(ser_take);

        st_d       = st_q;
        st_d.wptr  = st_q.wptr + AW'(push_n);
        st_d.rptr  = st_q.rptr + AW'(pop_n);
        st_d.level = st_q.level + push_n - pop_n;
        if (clear_i) begin
            st_d = '0;
        end

        put_cnt_o  = push_n[2:0];
        bus_take_o = bus_take[2:0];
        wptr_o     = st_q.wptr;
        rptr_o     = st_q.rptr;
        level_o    = st_q.level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/dbf_store.sv
module dbf_store #(
    parameter int DEPTH = 32,
    parameter int AW    = $clog2(DEPTH),
    parameter int LANES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [AW-1:0]        wptr_i,
    input  logic [2:0]           put_cnt_i,
    input  logic [8*LANES-1:0]   wdata_i,
    input  logic [AW-1:0]        rptr_i,
    output logic [8*LANES-1:0]   head_o
);

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            for (int k = 0; k < LANES; k++) begin
                if (3'(k) < put_cnt_i) begin
                    mem_q[AW'(wptr_i + AW'(k))] <= wdata_i[8*k +: 8];
                end
            end
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_head
        assign head_o[8*g +: 8] = mem_q[AW'(rptr_i + AW'(g))];
    end

endmodule

// File: rtl/dbf_thresh.sv
module dbf_thresh #(
    parameter int DEPTH = 32,
    parameter int LW    = $clog2(DEPTH) + 1,
    parameter int TW    = $clog2(DEPTH)
) (
    input  logic          rx_mode_i,
    input  logic [LW-1:0] level_i,
    input  logic [TW-1:0] thresh_i,
    output logic          flag_o
);

    logic [LW-1:0] room, limit;

    always_comb begin
        room   = LW'(DEPTH) - level_i;
        limit  = LW'(thresh_i) + LW'(1);
        flag_o = rx_mode_i ? (level_i >= limit) : (room >= limit);
    end

endmodule

// File: rtl/dualdir_byte_fifo.sv
module dualdir_byte_fifo #(
    parameter int DEPTH = 32,
    parameter int AW    = $clog2(DEPTH),
    parameter int LW    = AW + 1,
    parameter int TW    = AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          rx_mode_i,
    input  logic          busy_i,
    input  logic [TW-1:0] thresh_i,
    input  logic          bus_req_i,
    input  logic          bus_we_i,
    input  logic [1:0]    bus_size_i,
    input  logic [31:0]   bus_wdata_i,
    output logic [31:0]   bus_rdata_o,
    output logic          bus_stall_o,
    input  logic          ser_push_i,
    input  logic [7:0]    ser_din_i,
    input  logic          ser_pop_i,
    output logic [7:0]    ser_dout_o,
    output logic [LW-1:0] level_o,
    output logic          thresh_flag_o
);

    logic [2:0]    put_cnt, bus_take;
    logic [AW-1:0] wptr, rptr;
    logic [31:0]   wdata, head;

    assign wdata = rx_mode_i ? {24'b0, ser_din_i} : bus_wdata_i;

    dbf_ctrl #(.DEPTH(DEPTH), .AW(AW), .LW(LW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (clear_i),
        .rx_mode_i  (rx_mode_i),
        .busy_i     (busy_i),
        .bus_req_i  (bus_req_i),
        .bus_we_i   (bus_we_i),
        .bus_size_i (bus_size_i),
        .ser_push_i (ser_push_i),
        .ser_pop_i  (ser_pop_i),
        .stall_o    (bus_stall_o),
        .put_cnt_o  (put_cnt),
        .bus_take_o (bus_take),
        .wptr_o     (wptr),
        .rptr_o     (rptr),
        .level_o    (level_o)
    );

    dbf_store #(.DEPTH(DEPTH), .AW(AW), .LANES(4)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wptr_i    (wptr),
        .put_cnt_i (put_cnt),
        .wdata_i   (wdata),
        .rptr_i    (rptr),
        .head_o    (head)
    );

    dbf_thresh #(.DEPTH(DEPTH), .LW(LW), .TW(TW)) u_thresh (
        .rx_mode_i (rx_mode_i),
        .level_i   (level_o),
        .thresh_i  (thresh_i),
        .flag_o    (thresh_flag_o)
    );

    for (genvar g = 0; g < 4; g++) begin : g_rlane
        assign bus_rdata_o[8*g +: 8] = (3'(g) < bus_take) ? head[8*g +: 8] : 8'h00;
    end

    assign ser_dout_o = head[7:0];

endmodule

// File: rtl/dbf_checks.sv
module dbf_checks #(
    parameter int DEPTH = 32,
    parameter int LW    = $clog2(DEPTH) + 1,
    parameter int TW    = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clear_i,
    input logic          rx_mode_i,
    input logic          busy_i,
    input logic [TW-1:0] thresh_i,
    input logic          bus_req_i,
    input logic          bus_we_i,
    input logic          bus_stall_o,
    input logic          ser_push_i,
    input logic          ser_pop_i,
    input logic [LW-1:0] level_o,
    input logic          thresh_flag_o
);

    assert_level_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        level_o <= LW'(DEPTH));

    assert_clear_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> level_o == '0);

    assert_read_stall_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_i && !bus_we_i && bus_stall_o) |-> busy_i);

    assert_stalled_write_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !rx_mode_i && bus_req_i && bus_we_i && bus_stall_o && !ser_pop_i)
        |=> level_o == $past(level_o));

    assert_full_push_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && rx_mode_i && ser_push_i && !bus_req_i && level_o == LW'(DEPTH))
        |=> level_o == LW'(DEPTH));

    assert_wrong_dir_no_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_i && (bus_we_i == rx_mode_i)) |-> !bus_stall_o);

    assert_rx_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_mode_i && level_o > LW'(thresh_i)) |-> thresh_flag_o);

endmodule

bind dualdir_byte_fifo dbf_checks #(.DEPTH(DEPTH), .LW(LW), .TW(TW)) u_checks (
    .clk           (clk),
    .rst_n         (rst_n),
    .clear_i       (clear_i),
    .rx_mode_i     (rx_mode_i),
    .busy_i        (busy_i),
    .thresh_i      (thresh_i),
    .bus_req_i     (bus_req_i),
    .bus_we_i      (bus_we_i),
    .bus_stall_o   (bus_stall_o),
    .ser_push_i    (ser_push_i),
    .ser_pop_i     (ser_pop_i),
    .level_o       (level_o),
    .thresh_flag_o (thresh_flag_o)
);

// File: tb/dualdir_byte_fifo_test.sv
module dualdir_byte_fifo_test;

    localparam int DEPTH = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear_i = 1'b0, rx_mode_i = 1'b0, busy_i = 1'b0;
    logic [4:0]  thresh_i = 5'd7;
    logic        bus_req_i = 1'b0, bus_we_i = 1'b0;
    logic [1:0]  bus_size_i = 2'd0;
    logic [31:0] bus_wdata_i = '0;
    logic [31:0] bus_rdata_o;
    logic        bus_stall_o;
    logic        ser_push_i = 1'b0, ser_pop_i = 1'b0;
    logic [7:0]  ser_din_i = '0;
    logic [7:0]  ser_dout_o;
    logic [5:0]  level_o;
    logic        thresh_flag_o;

    always #5 clk = ~clk;

    dualdir_byte_fifo uut (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .rx_mode_i(rx_mode_i),
        .busy_i(busy_i), .thresh_i(thresh_i), .bus_req_i(bus_req_i),
        .bus_we_i(bus_we_i), .bus_size_i(bus_size_i), .bus_wdata_i(bus_wdata_i),
        .bus_rdata_o(bus_rdata_o), .bus_stall_o(bus_stall_o),
        .ser_push_i(ser_push_i), .ser_din_i(ser_din_i), .ser_pop_i(ser_pop_i),
        .ser_dout_o(ser_dout_o), .level_o(level_o), .thresh_flag_o(thresh_flag_o)
    );

    int    vectors = 0;
    int    errors  = 0;
    logic [7:0] q [DEPTH];
    int    cnt = 0;
    string lvl_tag = "R8";

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int nbytes(input logic [1:0] s);
        return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic exp_flag(input logic rx, input int lvl, input int th);
        return rx ? (lvl >= th + 1) : ((DEPTH - lvl) >= th + 1);
    endfunction

    // one cycle: inputs applied at negedge, outputs checked, model advanced
    task automatic cycle();
        int  n, take;
        logic dir_ok, ex_stall, accept;
        logic [31:0] ex_rd;
        #1;
        n        = nbytes(bus_size_i);
        dir_ok   = bus_we_i ? !rx_mode_i : rx_mode_i;
        ex_stall = bus_req_i && dir_ok &&
                   (bus_we_i ? ((DEPTH - cnt) < n) : ((cnt < n) && busy_i));
        accept   = bus_req_i && dir_ok && !ex_stall;
        take     = 0;
        ex_rd    = '0;
        if (accept && !bus_we_i) begin
            take = (cnt < n) ? cnt : n;
            for (int i = 0; i < take; i++) ex_rd[8*i +: 8] = q[i];
        end
        if (bus_req_i && !dir_ok) begin
            chk("R7 stall", {31'b0, bus_stall_o}, 32'd0);
            chk("R7 rdata", bus_rdata_o, 32'd0);
        end else if (bus_req_i) begin
            chk(bus_we_i ? "R4 stall" : "R5 stall", {31'b0, bus_stall_o}, {31'b0, ex_stall});
            if (!bus_we_i) chk(busy_i ? "R3 rdata" : "R5 rdata", bus_rdata_o, ex_rd);
        end
        if (cnt > 0) chk(rx_mode_i ? "R6 head" : "R2 head", {24'b0, ser_dout_o}, {24'b0, q[0]});

        lvl_tag = (bus_req_i && !dir_ok) || (rx_mode_i ? ser_pop_i : ser_push_i) ? "R7" : "R8";
        if (clear_i) begin
            cnt = 0;
            lvl_tag = "R10";
        end else begin
            if (!rx_mode_i) take = (ser_pop_i && cnt > 0) ? 1 : 0;
            for (int i = 0; i < DEPTH - take; i++) q[i] = q[i + take];
            if (rx_mode_i) begin
                if (ser_push_i && (cnt < DEPTH)) begin
                    q[cnt - take] = ser_din_i;
                    cnt++;
                end
            end else if (accept && bus_we_i) begin
                for (int i = 0; i < n; i++) q[cnt - take + i] = bus_wdata_i[8*i +: 8];
                cnt += n;
            end
            cnt -= take;
        end
        @(negedge clk);
        chk(lvl_tag, {26'b0, level_o}, cnt);
        chk("R9 flag", {31'b0, thresh_flag_o}, {31'b0, exp_flag(rx_mode_i, cnt, thresh_i)});
    endtask

    function automatic logic pct(input int p);
        return ($urandom % 100) < p;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        int unused;
        unused = $urandom(32'h5eed);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 level", {26'b0, level_o}, 0);
        chk("R1 stall", {31'b0, bus_stall_o}, 0);
        chk("R1 flag", {31'b0, thresh_flag_o}, 1);

        // directed: word write then halfword pop ordering, then overfill stall
        bus_req_i = 1; bus_we_i = 1; bus_size_i = 2'd2; bus_wdata_i = 32'hDEADBEEF;
        cycle();
        bus_req_i = 0; ser_pop_i = 1;
        cycle(); cycle();
        ser_pop_i = 0; bus_req_i = 1; bus_size_i = 2'd2;
        for (int i = 0; i < 10; i++) begin
            bus_wdata_i = $urandom;
            cycle();
        end
        bus_req_i = 0; clear_i = 1; rx_mode_i = 1; busy_i = 0;
        cycle();
        // directed: read from empty with busy low returns nothing
        clear_i = 0; bus_req_i = 1; bus_we_i = 0; bus_size_i = 2'd2;
        cycle();
        bus_req_i = 0;

        for (int rep = 0; rep < 3; rep++) begin
            for (int ph = 0; ph < 4; ph++) begin
                rx_mode_i = (ph >= 2);
                thresh_i  = 5'($urandom % 32);
                clear_i   = 1'b1;
                bus_req_i = 1'b0; ser_push_i = 1'b0; ser_pop_i = 1'b0;
                cycle();
                clear_i = 1'b0;
                for (int c = 0; c < 400; c++) begin
                    bus_size_i  = 2'($urandom % 4);
                    bus_wdata_i = $urandom;
                    ser_din_i   = 8'($urandom);
                    case (ph)
                        0: begin bus_req_i = pct(70); bus_we_i = pct(90); ser_pop_i = pct(10);
                                 ser_push_i = pct(5); busy_i = pct(50); end
                        1: begin bus_req_i = pct(20); bus_we_i = pct(80); ser_pop_i = pct(80);
                                 ser_push_i = pct(5); busy_i = pct(50); end
                        2: begin bus_req_i = pct(20); bus_we_i = pct(10); ser_push_i = pct(80);
                                 ser_pop_i = pct(5); busy_i = 1'b1; end
                        default: begin bus_req_i = pct(70); bus_we_i = pct(10); ser_push_i = pct(15);
                                 ser_pop_i = pct(5); busy_i = pct(50); end
                    endcase
                    cycle();
                end
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule